// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protection Guard

This unit keeps the status byte of a serial EEPROM and rules on every write the device is asked to perform. It holds the write-enable latch, the ready/busy indication, a two-bit block-protect level and a bit that arms the write-protect pin. An upstream command decoder hands it one-cycle strobes for set-enable, clear-enable and status-write (with its data byte). It also presents array write requests, each carrying an address, over a valid/ready channel. The unit answers each array request with a one-cycle grant or deny pulse. It always drives the byte that a status read returns.

The nonvolatile fields (pin-arm bit and protect level) are registers with parameterised reset values. A status write lands in them only after an internal cycle of `TWC_CYCLES` clocks. That cycle starts when chip select rises after an accepted status-write command. An array write, once granted, counts as internal activity until the array engine's busy signal falls. A status read during any internal activity returns all ones.

Array request channel: a request transfers on a clock where `wreq_valid_i` and `wreq_ready_o` are both high. `wreq_ready_o` is low during any internal activity, including the gap between a grant and the end of that array cycle. While ready is low, the requester must hold valid and the address steady. The grant or deny pulse appears on the clock after the transfer.

Top module: `eeprom_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 (with default reset values), `wreq_ready_o` is 1, and `grant_o` and `deny_o` are 0.
- R2: When idle, the status byte is {pin-arm, 0, 0, 0, protect[1], protect[0], write-enable, 0}: bit 7 is the pin-arm bit, bits 3:2 are the protect level, bit 1 is the latch and bit 0 is the busy flag. A set-enable strobe makes bit 1 read 1.
- R3: A clear-enable strobe clears the latch at either level of `wp_n_i`.
- R4: During internal activity the status reads 0xFF and `wreq_ready_o` is 0. Internal activity means `array_busy_i` high, a granted array write not yet finished, or a status cycle. During it, set-enable, clear-enable and status-write strobes have no effect.
- R5: A status-write strobe is taken only while the latch is set. It stores data bits 7, 3 and 2 and ignores bits 6:4, 1 and 0. The new value appears `TWC_CYCLES` clocks after chip select rises, and the latch is then clear. Without the latch set, the strobe starts no cycle.
- R6: When the pin-arm bit is 1 and `wp_n_i` is 0, a status-write strobe is refused and the latch is cleared. When the pin-arm bit is 0, `wp_n_i` has no effect.
- R7: If `wp_n_i` goes low with chip select still low, the pin-arm bit is 1 and a status write is pending, that write is dropped and the latch is cleared. Once the status cycle has started, `wp_n_i` does not affect it.
- R8: The protect level maps onto the top of the address space: 00 protects nothing, 01 the top quarter (0x1800-0x1FFF for 13 address bits), 10 the top half (0x1000-0x1FFF) and 11 the whole array.
- R9: An array request is granted when the latch is set and the address is outside the protected zone. Otherwise it is denied. The pulse comes one clock after the transfer. A denial caused by protection clears the latch.
- R10: When `array_busy_i` falls after a granted write, the latch is cleared and ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low; rising edge launches a pending status write |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_wren_i | input | 1 | Set-enable strobe |
| cmd_wrdi_i | input | 1 | Clear-enable strobe |
| cmd_wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Status-write data byte |
| wreq_valid_i | input | 1 | Array write request valid |
| wreq_ready_o | output | 1 | Array write request ready |
| wreq_addr_i | input | ADDR_W | Array write request address |
| array_busy_i | input | 1 | Array engine internal write in progress |
| status_o | output | 8 | Status read byte |
| grant_o | output | 1 | Request granted pulse |
| deny_o | output | 1 | Request denied pulse |

## Verification
The protect decision is swept over all four protect levels. For each level, 128 addresses step through every 64-byte block with varying low bits, and the addresses on either side of each zone edge are added. This separates a wrong threshold from a wrong level decode. Status writes are tried with the latch clear, with the pin low and the arm bit set or clear, and with the pin dropping before or after chip select rises. Together these separate refusal, cancellation and commit. Commands sent while the array engine is busy show whether such strobes are truly ignored rather than merely masked by the all-ones read.

// File: rtl/esg_pkg.sv
package esg_pkg;
  typedef struct packed {
    logic       arm;
    logic [1:0] lvl;
  } nv_bits_t;

  localparam int unsigned SB_ARM  = 7;
  localparam int unsigned SB_LVL1 = 3;
  localparam int unsigned SB_LVL0 = 2;
  localparam int unsigned SB_WEL  = 1;
  localparam int unsigned SB_BUSY = 0;

  function automatic logic [7:0] pack_status(nv_bits_t nv, logic wel);
    logic [7:0] s;
    s = '0;
    s[SB_ARM]  = nv.arm;
    s[SB_LVL1] = nv.lvl[1];
    s[SB_LVL0] = nv.lvl[0];
    s[SB_WEL]  = wel;
    s[SB_BUSY] = 1'b0;
    return s;
  endfunction

  function automatic nv_bits_t unpack_nv(logic [7:0] d);
    nv_bits_t n;
    n.arm = d[SB_ARM];
    n.lvl = {d[SB_LVL1], d[SB_LVL0]};
    return n;
  endfunction
endpackage

// File: rtl/esg_zone_cmp.sv
module esg_zone_cmp #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [1:0]        lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic top_quarter, top_half;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_quarter = addr_i[TOP] & addr_i[TOP-1];
      assign top_half    = addr_i[TOP];
    end else begin : g_narrow
      assign top_quarter = addr_i[TOP];
      assign top_half    = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (lvl_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = top_quarter;
      2'b10:   hit_o = top_half;
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/esg_nv_timer.sv
module esg_nv_timer #(
  parameter int unsigned TWC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (TWC_CYCLES < 2) ? 1 : $clog2(TWC_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TWC_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R5
  twc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import esg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned TWC_CYCLES = 16,
  parameter logic        ARM_RST    = 1'b0,
  parameter logic [1:0]  LVL_RST    = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              wp_n_i,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              wreq_valid_i,
  output logic              wreq_ready_o,
  input  logic [ADDR_W-1:0] wreq_addr_i,
  input  logic              array_busy_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              deny_o
);
  nv_bits_t nv_q, pend_nv_q;
  logic     wel_q, pend_q, cs_q, abusy_q, inflight_q, grant_q, deny_q;
  logic     sw_busy, sw_done, zone_hit;

  logic busy_any, wp_lock, cs_rise, req_fire, req_ok, arr_done;
  logic wrsr_take, wrsr_block, cancel, sw_start, prot_deny;

  esg_zone_cmp #(.ADDR_W(ADDR_W)) u_zone (
    .lvl_i  (nv_q.lvl),
    .addr_i (wreq_addr_i),
    .hit_o  (zone_hit)
  );

  esg_nv_timer #(.TWC_CYCLES(TWC_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (sw_start),
    .busy_o  (sw_busy),
    .done_o  (sw_done)
  );

  assign busy_any   = array_busy_i | sw_busy | inflight_q;
  assign wp_lock    = nv_q.arm & ~wp_n_i;
  assign cs_rise    = ~cs_q & cs_n_i;
  assign req_fire   = wreq_valid_i & wreq_ready_o;
  assign req_ok     = wel_q & ~zone_hit;
  assign prot_deny  = req_fire & wel_q & zone_hit;
  assign arr_done   = inflight_q & abusy_q & ~array_busy_i;
  assign wrsr_take  = cmd_wrsr_i & ~busy_any & wel_q & ~wp_lock;
  assign wrsr_block = cmd_wrsr_i & ~busy_any & wel_q & wp_lock;
  assign cancel     = pend_q & ~cs_n_i & wp_lock;
  assign sw_start   = pend_q & cs_rise;

  assign wreq_ready_o = ~busy_any;
  assign status_o     = busy_any ? 8'hFF : pack_status(nv_q, wel_q);
  assign grant_o      = grant_q;
  assign deny_o       = deny_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      abusy_q <= 1'b0;
    end else begin
      cs_q    <= cs_n_i;
      abusy_q <= array_busy_i;
    end
  end

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (sw_done || arr_done) begin
      wel_q <= 1'b0;
    end else if (cancel || wrsr_block || prot_deny) begin
      wel_q <= 1'b0;
    end else if (!busy_any && cmd_wrdi_i) begin
      wel_q <= 1'b0;
    end else if (!busy_any && cmd_wren_i) begin
      wel_q <= 1'b1;
    end
  end

  // pending status write and nonvolatile fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_nv_q <= '{arm: ARM_RST, lvl: LVL_RST};
      nv_q      <= '{arm: ARM_RST, lvl: LVL_RST};
    end else begin
      if (cancel || sw_start) pend_q <= 1'b0;
      else if (wrsr_take) begin
        pend_q    <= 1'b1;
        pend_nv_q <= unpack_nv(wrsr_data_i);
      end
      if (sw_done) nv_q <= pend_nv_q;
    end
  end

  // array request decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q    <= 1'b0;
      deny_q     <= 1'b0;
      inflight_q <= 1'b0;
    end else begin
      grant_q <= req_fire & req_ok;
      deny_q  <= req_fire & ~req_ok;
      if (req_fire && req_ok) inflight_q <= 1'b1;
      else if (arr_done)      inflight_q <= 1'b0;
    end
  end

  // R4
  busy_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_busy_i |-> (status_o == 8'hFF && !wreq_ready_o));

  // R9
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (status_o == 8'hFF));

  // R9
  deny_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_o && $past(zone_hit)) |-> !wel_q);

  // R6
  wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && wp_lock) |=> !pend_q);

  // R5
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |=> !wel_q);
endmodule

// File: tb/eeprom_status_guard_tb.sv
module eeprom_status_guard_tb;
  localparam int unsigned AW  = 13;
  localparam int unsigned TWC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0] wdata = '0;
  logic valid = 1'b0, ready, abusy = 1'b0, grant, deny;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_status_guard #(.ADDR_W(AW), .TWC_CYCLES(TWC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wp_n_i(wp_n),
    .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr),
    .wrsr_data_i(wdata), .wreq_valid_i(valid), .wreq_ready_o(ready),
    .wreq_addr_i(addr), .array_busy_i(abusy), .status_o(status),
    .grant_o(grant), .deny_o(deny)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic p_wren; tick; wren = 1'b1; tick; wren = 1'b0; endtask
  task automatic p_wrdi; tick; wrdi = 1'b1; tick; wrdi = 1'b0; endtask
  task automatic p_wrsr(input logic [7:0] d);
    tick; wrsr = 1'b1; wdata = d; tick; wrsr = 1'b0;
  endtask

  task automatic set_sr(input logic [7:0] d, input logic [7:0] exp);
    cs_n = 1'b0; p_wren; p_wrsr(d); tick; cs_n = 1'b1; tick;
    chk("R4 status during status cycle", {8'h0, status}, 16'h00FF);
    repeat (TWC + 1) tick;
    chk("R5 status after commit", {8'h0, status}, {8'h0, exp});
  endtask

  function automatic bit exp_prot(input int lvl, input int a);
    int lim;
    lim = (lvl == 1) ? 6144 : (lvl == 2) ? 4096 : (lvl == 3) ? 0 : 8192;
    return a >= lim;
  endfunction

  task automatic try_req(input int lvl, input int a);
    bit p;
    p = exp_prot(lvl, a);
    p_wren;
    chk("R9 ready before request", {15'h0, ready}, 16'h1);
    valid = 1'b1; addr = AW'(a); tick; valid = 1'b0;
    chk("R8 grant vs zone", {15'h0, grant}, {15'h0, !p});
    chk("R8 deny vs zone", {15'h0, deny}, {15'h0, p});
    if (p) begin
      chk("R9 latch cleared by protect deny", {8'h0, status}, 16'(lvl << 2));
    end else begin
      chk("R4 ready low after grant", {15'h0, ready}, 16'h0);
      tick; abusy = 1'b1; tick; tick; abusy = 1'b0; tick;
      chk("R10 latch clear after array cycle", {8'h0, status}, 16'(lvl << 2));
      chk("R10 ready back", {15'h0, ready}, 16'h1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R1
    chk("R1 reset status", {8'h0, status}, 16'h0000);
    chk("R1 reset ready", {15'h0, ready}, 16'h1);
    chk("R1 reset pulses", {14'h0, grant, deny}, 16'h0);

    // R2, R3 with the pin low and arm clear
    wp_n = 1'b0;
    p_wren;
    chk("R2 latch bit", {8'h0, status}, 16'h0002);
    p_wrdi;
    chk("R3 clear latch pin low", {8'h0, status}, 16'h0000);
    wp_n = 1'b1;

    // R5 status write without latch
    cs_n = 1'b0; p_wrsr(8'hFF); tick; cs_n = 1'b1; tick;
    chk("R5 no cycle without latch", {8'h0, status}, 16'h0000);

    // R9 request with latch clear
    tick; valid = 1'b1; addr = '0; tick; valid = 1'b0;
    chk("R9 deny without latch", {14'h0, grant, deny}, 16'h0001);

    // R4 strobes ignored while array busy
    tick; abusy = 1'b1;
    p_wren;
    chk("R4 status ones while busy", {8'h0, status}, 16'h00FF);
    tick; abusy = 1'b0; tick;
    chk("R4 set-enable ignored when busy", {8'h0, status}, 16'h0000);

    // R5 only bits 7,3,2 stored
    set_sr(8'hFF, 8'h8C);

    // R6 arm set and pin low refuses
    wp_n = 1'b0; cs_n = 1'b0;
    p_wren;
    chk("R6 latch set pin low", {8'h0, status}, 16'h008E);
    p_wrsr(8'h00);
    chk("R6 refuse clears latch", {8'h0, status}, 16'h008C);
    tick; cs_n = 1'b1; tick;
    chk("R6 no status cycle", {8'h0, status}, 16'h008C);
    wp_n = 1'b1;

    // R7 pin drop before chip select rises cancels
    cs_n = 1'b0; p_wren; p_wrsr(8'h00);
    tick; wp_n = 1'b0; tick;
    chk("R7 cancel clears latch", {8'h0, status}, 16'h008C);
    tick; cs_n = 1'b1; tick;
    chk("R7 cancelled write no cycle", {8'h0, status}, 16'h008C);
    wp_n = 1'b1;

    // R7 pin drop after cycle start has no effect
    cs_n = 1'b0; p_wren; p_wrsr(8'h00);
    tick; cs_n = 1'b1; tick;
    chk("R7 cycle started", {8'h0, status}, 16'h00FF);
    wp_n = 1'b0;
    repeat (TWC + 1) tick;
    chk("R7 commit despite pin", {8'h0, status}, 16'h0000);

    // R6 arm clear: pin ignored
    set_sr(8'h04, 8'h04);
    wp_n = 1'b1;

    // R8, R9, R10 sweep
    for (int lvl = 0; lvl < 4; lvl++) begin
      set_sr(8'(lvl << 2), 8'(lvl << 2));
      for (int k = 0; k < 128; k++) try_req(lvl, k * 64 + (k % 64));
      try_req(lvl, 16'h0FFF);
      try_req(lvl, 16'h1000);
      try_req(lvl, 16'h17FF);
      try_req(lvl, 16'h1800);
      try_req(lvl, 16'h1FFF);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule